// File: doc/BRIEF.md
# Temperature limit monitor with alert outputs

This block checks two temperature readings against a set of programmable thresholds, one for the on-die sensor and one for an external diode. The readings are 11-bit two's-complement values in steps of 0.125 °C. Each reading is judged only on the cycle its sample strobe is high. The results go into status bits of three kinds. Some follow the latest comparison. One is set-only and cleared when software reads it. Two are set-only and cleared by a read, and after that read they stay off until the channel has cooled by a fixed margin.

From these bits the block drives four outputs. An active-low alert line combines every enabled pending event with the critical bits, which no enable can mask. An active-low over-temperature line follows the critical bits. An active-low throttle line follows the THERM level comparison. A fan full-speed request is raised by the THERM bits when forcing is enabled. The limits are whole degrees held in 8-bit signed registers. A limit is compared against a temperature by appending three zero fraction bits to it.

Top module: `tmon_limit_monitor`

## Requirements
- R1: On a cycle with `smp_valid` high, the next clock sets `hi_flag[c]` to (temp ≥ high limit × 8), `lo_flag[c]` to (temp ≤ low limit × 8) and `crit_flag[c]` to (temp ≥ critical limit × 8). All temperatures are counted in eighths of a degree. Index 0 is the local channel and index 1 is the remote channel. On cycles without a sample these bits hold their values.
- R2: `oor_flag[c]` equals `hi_flag[c] | lo_flag[c]`, updated on the same sample. It pulls `alert_n` low only while that channel's out-of-range enable is 1.
- R3: While any `crit_flag` bit is 1, `ovr_n` is 0 and `alert_n` is 0, whatever the enables are.
- R4: `psv_flag` sets on a sample where the control temperature is ≤ passive limit × 8. It stays set until a cycle with `rd_aux` high clears it. A clear and a set on the same cycle leave it clear, and the next qualifying sample sets it again. It drives `alert_n` low only when `ie_psv` is 1.
- R5: `ctl_sel` picks the control temperature: 0 picks the local reading, 1 picks the remote reading, and 2 or 3 pick the greater of the two.
- R6: A sample with a channel ≥ THERM limit × 8 sets that channel's `therm_flag` bit if the channel is armed. `therm_n` is 0 while the latest sample of either channel was ≥ THERM limit × 8. Any set THERM bit pulls `alert_n` low when `ie_therm` is 1.
- R7: `rd_main` clears both THERM bits, and this clear takes priority over a set. A channel whose bit was set when cleared is disarmed. It re-arms on a sample at or below (THERM limit − 5) × 8, where the subtraction saturates at −128.
- R8: `fan_full` equals `fan_force_en` AND (either THERM bit set).
- R9: After reset all status bits are 0, both channels are armed, `alert_n`, `ovr_n` and `therm_n` are 1, and `fan_full` is 0.
- R10: `alert_n` returns to 1 once every bit that pulls it low has cleared or lost its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Both temperature inputs hold a fresh sample |
| loc_temp | input | 11 | Local temperature, signed, 0.125 °C per LSB |
| rem_temp | input | 11 | Remote temperature, signed, 0.125 °C per LSB |
| loc_hi_lim | input | 8 | Local high limit, signed °C |
| loc_lo_lim | input | 8 | Local low limit, signed °C |
| loc_crit_lim | input | 8 | Local critical limit, signed °C |
| rem_hi_lim | input | 8 | Remote high limit, signed °C |
| rem_lo_lim | input | 8 | Remote low limit, signed °C |
| rem_crit_lim | input | 8 | Remote critical limit, signed °C |
| psv_lim | input | 8 | Passive cooling limit, signed °C |
| therm_lim | input | 8 | THERM limit shared by both channels, signed °C |
| ctl_sel | input | 2 | Control temperature select (0 local, 1 remote, 2/3 greater) |
| ie_loc_oor | input | 1 | Alert enable, local out-of-range |
| ie_rem_oor | input | 1 | Alert enable, remote out-of-range |
| ie_psv | input | 1 | Alert enable, passive cooling |
| ie_therm | input | 1 | Alert enable, THERM bits |
| fan_force_en | input | 1 | Let THERM bits request full fan speed |
| rd_main | input | 1 | Read strobe of the main status register, clears THERM bits |
| rd_aux | input | 1 | Read strobe of the auxiliary status register, clears passive bit |
| hi_flag | output | 2 | High-limit bits [remote, local] |
| lo_flag | output | 2 | Low-limit bits [remote, local] |
| oor_flag | output | 2 | Out-of-range bits [remote, local] |
| crit_flag | output | 2 | Critical bits [remote, local] |
| therm_flag | output | 2 | THERM bits [remote, local] |
| psv_flag | output | 1 | Passive cooling bit |
| alert_n | output | 1 | Active-low combined alert |
| ovr_n | output | 1 | Active-low over-temperature |
| therm_n | output | 1 | Active-low throttle request |
| fan_full | output | 1 | Fan full-speed request |

## Verification
The properties take read strobes and sample strobes as free inputs, with no rule on how they combine. They do assume that the limit registers and enables are valid logic levels whenever reset is low. The stimulus changes temperatures, limits, enables and strobes only on the falling clock edge, so every rising edge sees one coherent set of inputs. It combines reads with samples on purpose, both on the same cycle and apart, to reach the clear-over-set cases. It also places temperatures exactly on each threshold, one LSB on either side of it, and at the −128 °C floor, where the THERM re-arm level saturates.

// File: rtl/tmon_pkg.sv
package tmon_pkg;

    localparam int TEMP_W     = 11;
    localparam int FRAC_W     = 3;
    localparam int LIM_W      = 8;
    localparam int REARM_DROP = 5;
    localparam int NCH        = 2;

    typedef logic signed [TEMP_W-1:0] temp_t;
    typedef logic signed [LIM_W-1:0]  lim_t;

    typedef enum logic [1:0] {
        CTL_LOCAL  = 2'd0,
        CTL_REMOTE = 2'd1,
        CTL_HOTTER = 2'd2
    } ctl_sel_e;

    typedef struct packed {
        lim_t hi;
        lim_t lo;
        lim_t crit;
    } chan_lim_t;

    typedef struct packed {
        logic hi;
        logic lo;
        logic crit;
        logic hot;
        logic cool;
    } cmp_t;

    // whole-degree limit placed on the integer part of a sample
    function automatic temp_t align_lim(lim_t l);
        temp_t r;
        r = temp_t'(l);
        return r <<< FRAC_W;
    endfunction

    // THERM limit minus the re-arm margin, clamped at the most negative value
    function automatic lim_t rearm_level(lim_t l);
        logic [LIM_W:0] d;
        d = {l[LIM_W-1], l} - (LIM_W+1)'(REARM_DROP);
        if (d[LIM_W] != d[LIM_W-1])
            return {1'b1, {(LIM_W-1){1'b0}}};
        return d[LIM_W-1:0];
    endfunction

    function automatic temp_t hotter(temp_t a, temp_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tmon_chan_cmp.sv
module tmon_chan_cmp
    import tmon_pkg::*;
(
    input  temp_t     temp_i,
    input  chan_lim_t lim_i,
    input  lim_t      therm_lim_i,
    output cmp_t      cmp_o
);
    always_comb begin
        cmp_o.hi   = temp_i >= align_lim(lim_i.hi);
        cmp_o.lo   = temp_i <= align_lim(lim_i.lo);
        cmp_o.crit = temp_i >= align_lim(lim_i.crit);
        cmp_o.hot  = temp_i >= align_lim(therm_lim_i);
        cmp_o.cool = temp_i <= align_lim(rearm_level(therm_lim_i));
    end
endmodule

// File: rtl/tmon_therm_trk.sv
module tmon_therm_trk (
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    input  logic rd_clr,
    input  logic hot,
    input  logic cool,
    output logic flag
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b1;
        end else if (rd_clr) begin
            flag <= 1'b0;
            if (flag)
                armed <= 1'b0;
        end else if (smp_valid) begin
            if (armed && hot)
                flag <= 1'b1;
            if (cool)
                armed <= 1'b1;
        end
    end
endmodule

// File: rtl/tmon_alert_gen.sv
module tmon_alert_gen
    import tmon_pkg::*;
(
    input  logic [NCH-1:0] oor,
    input  logic [NCH-1:0] ie_oor,
    input  logic [NCH-1:0] crit,
    input  logic [NCH-1:0] therm_bits,
    input  logic [NCH-1:0] therm_lvl,
    input  logic           psv,
    input  logic           ie_psv,
    input  logic           ie_therm,
    input  logic           fan_force_en,
    output logic           alert_n,
    output logic           ovr_n,
    output logic           therm_n,
    output logic           fan_full
);
    logic maskable;

    always_comb begin
        maskable = (|(oor & ie_oor)) | (psv & ie_psv) | ((|therm_bits) & ie_therm);
        alert_n  = !(maskable | (|crit));
        ovr_n    = !(|crit);
        therm_n  = !(|therm_lvl);
        fan_full = fan_force_en & (|therm_bits);
    end
endmodule

// File: rtl/tmon_limit_monitor.sv
module tmon_limit_monitor
    import tmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [TEMP_W-1:0] loc_temp,
    input  logic [TEMP_W-1:0] rem_temp,
    input  logic [LIM_W-1:0]  loc_hi_lim,
    input  logic [LIM_W-1:0]  loc_lo_lim,
    input  logic [LIM_W-1:0]  loc_crit_lim,
    input  logic [LIM_W-1:0]  rem_hi_lim,
    input  logic [LIM_W-1:0]  rem_lo_lim,
    input  logic [LIM_W-1:0]  rem_crit_lim,
    input  logic [LIM_W-1:0]  psv_lim,
    input  logic [LIM_W-1:0]  therm_lim,
    input  logic [1:0]        ctl_sel,
    input  logic              ie_loc_oor,
    input  logic              ie_rem_oor,
    input  logic              ie_psv,
    input  logic              ie_therm,
    input  logic              fan_force_en,
    input  logic              rd_main,
    input  logic              rd_aux,
    output logic [NCH-1:0]    hi_flag,
    output logic [NCH-1:0]    lo_flag,
    output logic [NCH-1:0]    oor_flag,
    output logic [NCH-1:0]    crit_flag,
    output logic [NCH-1:0]    therm_flag,
    output logic              psv_flag,
    output logic              alert_n,
    output logic              ovr_n,
    output logic              therm_n,
    output logic              fan_full
);
    temp_t          temps [NCH];
    chan_lim_t      lims  [NCH];
    cmp_t           cmp   [NCH];
    logic [NCH-1:0] lvl_q;
    temp_t          ctl_temp;
    logic           psv_hit;

    assign temps[0] = loc_temp;
    assign temps[1] = rem_temp;
    assign lims[0]  = '{hi: loc_hi_lim, lo: loc_lo_lim, crit: loc_crit_lim};
    assign lims[1]  = '{hi: rem_hi_lim, lo: rem_lo_lim, crit: rem_crit_lim};

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            tmon_chan_cmp u_cmp (
                .temp_i      (temps[c]),
                .lim_i       (lims[c]),
                .therm_lim_i (therm_lim),
                .cmp_o       (cmp[c])
            );
            tmon_therm_trk u_trk (
                .clk       (clk),
                .rst       (rst),
                .smp_valid (smp_valid),
                .rd_clr    (rd_main),
                .hot       (cmp[c].hot),
                .cool      (cmp[c].cool),
                .flag      (therm_flag[c])
            );
        end
    endgenerate

    // level-following status, refreshed only on a sample
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_flag   <= '0;
            lo_flag   <= '0;
            oor_flag  <= '0;
            crit_flag <= '0;
            lvl_q     <= '0;
        end else if (smp_valid) begin
            for (int c = 0; c < NCH; c++) begin
                hi_flag[c]   <= cmp[c].hi;
                lo_flag[c]   <= cmp[c].lo;
                oor_flag[c]  <= cmp[c].hi | cmp[c].lo;
                crit_flag[c] <= cmp[c].crit;
                lvl_q[c]     <= cmp[c].hot;
            end
        end
    end

    always_comb begin
        case (ctl_sel_e'(ctl_sel))
            CTL_LOCAL:  ctl_temp = temps[0];
            CTL_REMOTE: ctl_temp = temps[1];
            default:    ctl_temp = hotter(temps[0], temps[1]);
        endcase
        psv_hit = ctl_temp <= align_lim(psv_lim);
    end

    // passive cooling: set-only, read clears with priority
    always_ff @(posedge clk) begin
        if (rst)
            psv_flag <= 1'b0;
        else if (rd_aux)
            psv_flag <= 1'b0;
        else if (smp_valid && psv_hit)
            psv_flag <= 1'b1;
    end

    tmon_alert_gen u_alert (
        .oor          (oor_flag),
        .ie_oor       ({ie_rem_oor, ie_loc_oor}),
        .crit         (crit_flag),
        .therm_bits   (therm_flag),
        .therm_lvl    (lvl_q),
        .psv          (psv_flag),
        .ie_psv       (ie_psv),
        .ie_therm     (ie_therm),
        .fan_force_en (fan_force_en),
        .alert_n      (alert_n),
        .ovr_n        (ovr_n),
        .therm_n      (therm_n),
        .fan_full     (fan_full)
    );
endmodule

// File: rtl/tmon_limit_monitor_chk.sv
module tmon_limit_monitor_chk (
    input logic       clk,
    input logic       rst,
    input logic       smp_valid,
    input logic       ie_loc_oor,
    input logic       ie_rem_oor,
    input logic       fan_force_en,
    input logic       rd_main,
    input logic       rd_aux,
    input logic [1:0] hi_flag,
    input logic [1:0] lo_flag,
    input logic [1:0] oor_flag,
    input logic [1:0] crit_flag,
    input logic [1:0] therm_flag,
    input logic       psv_flag,
    input logic       alert_n,
    input logic       ovr_n,
    input logic       therm_n,
    input logic       fan_full
);
    p_hold_between_samples_r1: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> ($stable(hi_flag) && $stable(lo_flag) && $stable(crit_flag)));

    p_oor_alert_r2: assert property (@(posedge clk) disable iff (rst)
        ((oor_flag[0] && ie_loc_oor) || (oor_flag[1] && ie_rem_oor)) |-> !alert_n);

    p_crit_nonmaskable_r3: assert property (@(posedge clk) disable iff (rst)
        (|crit_flag) |-> (!alert_n && !ovr_n));

    p_psv_read_clears_r4: assert property (@(posedge clk) disable iff (rst)
        rd_aux |=> !psv_flag);

    p_therm_needs_sample_r6: assert property (@(posedge clk) disable iff (rst)
        ((therm_flag & ~$past(therm_flag)) != 2'b00) |-> $past(smp_valid));

    p_therm_read_clears_r7: assert property (@(posedge clk) disable iff (rst)
        rd_main |=> (therm_flag == 2'b00));

    p_fan_gated_r8: assert property (@(posedge clk) disable iff (rst)
        !fan_force_en |-> !fan_full);

    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |=> (hi_flag == 2'b00 && lo_flag == 2'b00 && therm_flag == 2'b00
                 && !psv_flag && alert_n && ovr_n && therm_n));
endmodule

bind tmon_limit_monitor tmon_limit_monitor_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .ie_loc_oor   (ie_loc_oor),
    .ie_rem_oor   (ie_rem_oor),
    .fan_force_en (fan_force_en),
    .rd_main      (rd_main),
    .rd_aux       (rd_aux),
    .hi_flag      (hi_flag),
    .lo_flag      (lo_flag),
    .oor_flag     (oor_flag),
    .crit_flag    (crit_flag),
    .therm_flag   (therm_flag),
    .psv_flag     (psv_flag),
    .alert_n      (alert_n),
    .ovr_n        (ovr_n),
    .therm_n      (therm_n),
    .fan_full     (fan_full)
);

// File: tb/test_tmon_limit_monitor.sv
module test_tmon_limit_monitor;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic smp_valid = 0, rd_main = 0, rd_aux = 0;
    logic ie_loc_oor = 0, ie_rem_oor = 0, ie_psv = 0, ie_therm = 0, fan_force_en = 0;
    logic [1:0] ctl_sel = 2'd2;
    int lt = 0, rt = 0;
    int l_hi = 50, l_lo = -10, l_cr = 100, r_hi = 60, r_lo = 0, r_cr = 90, p_lim = 30, th_lim = 80;

    logic [1:0] hi_flag, lo_flag, oor_flag, crit_flag, therm_flag;
    logic psv_flag, alert_n, ovr_n, therm_n, fan_full;

    tmon_limit_monitor i_tmon_limit_monitor (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .loc_temp(11'(lt)), .rem_temp(11'(rt)),
        .loc_hi_lim(8'(l_hi)), .loc_lo_lim(8'(l_lo)), .loc_crit_lim(8'(l_cr)),
        .rem_hi_lim(8'(r_hi)), .rem_lo_lim(8'(r_lo)), .rem_crit_lim(8'(r_cr)),
        .psv_lim(8'(p_lim)), .therm_lim(8'(th_lim)), .ctl_sel(ctl_sel),
        .ie_loc_oor(ie_loc_oor), .ie_rem_oor(ie_rem_oor), .ie_psv(ie_psv),
        .ie_therm(ie_therm), .fan_force_en(fan_force_en),
        .rd_main(rd_main), .rd_aux(rd_aux),
        .hi_flag(hi_flag), .lo_flag(lo_flag), .oor_flag(oor_flag),
        .crit_flag(crit_flag), .therm_flag(therm_flag), .psv_flag(psv_flag),
        .alert_n(alert_n), .ovr_n(ovr_n), .therm_n(therm_n), .fan_full(fan_full)
    );

    typedef struct {
        int          due;
        logic [14:0] exp;
        string       tag;
    } item_t;
    item_t q[$];

    int cyc = 0, n_chk = 0, n_bad = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference state, built from the requirements
    logic [1:0] m_hi = 0, m_lo = 0, m_cr = 0, m_lvl = 0, m_th = 0, m_arm = 2'b11;
    logic m_psv = 0;

    function automatic int deg(int d);
        return d * 8;
    endfunction

    task automatic step(input bit v, input bit rm, input bit ra, input string tag);
        int t[2];
        int ctl, cool_lvl;
        logic al;
        item_t it;
        smp_valid = v; rd_main = rm; rd_aux = ra;
        t[0] = lt; t[1] = rt;
        cool_lvl = (th_lim - 5 < -128) ? -128 : th_lim - 5;
        if (v) begin
            m_hi[0] = t[0] >= deg(l_hi); m_lo[0] = t[0] <= deg(l_lo); m_cr[0] = t[0] >= deg(l_cr);
            m_hi[1] = t[1] >= deg(r_hi); m_lo[1] = t[1] <= deg(r_lo); m_cr[1] = t[1] >= deg(r_cr);
        end
        for (int c = 0; c < 2; c++) begin
            if (rm) begin
                if (m_th[c]) m_arm[c] = 0;
                m_th[c] = 0;
            end else if (v) begin
                if (m_arm[c] && t[c] >= deg(th_lim)) m_th[c] = 1;
                if (t[c] <= deg(cool_lvl)) m_arm[c] = 1;
            end
            if (v) m_lvl[c] = t[c] >= deg(th_lim);
        end
        ctl = (ctl_sel == 2'd0) ? t[0] : (ctl_sel == 2'd1) ? t[1] : ((t[0] > t[1]) ? t[0] : t[1]);
        if (ra) m_psv = 0;
        else if (v && ctl <= deg(p_lim)) m_psv = 1;
        al = ((m_hi[0] | m_lo[0]) & ie_loc_oor) | ((m_hi[1] | m_lo[1]) & ie_rem_oor)
           | (m_psv & ie_psv) | ((|m_th) & ie_therm) | (|m_cr);
        it.due = cyc + 1;
        it.exp = {m_hi, m_lo, m_hi | m_lo, m_cr, m_th, m_psv, !al, !(|m_cr), !(|m_lvl),
                  fan_force_en & (|m_th)};
        it.tag = tag;
        q.push_back(it);
        @(negedge clk);
        smp_valid = 0; rd_main = 0; rd_aux = 0;
    endtask

    // monitor: compare mid-way through the high phase
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0 && q[0].due <= cyc) begin
                item_t it;
                logic [14:0] act;
                it  = q.pop_front();
                act = {hi_flag, lo_flag, oor_flag, crit_flag, therm_flag, psv_flag,
                       alert_n, ovr_n, therm_n, fan_full};
                n_chk++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        lt = deg(25); rt = deg(40);
        step(0, 0, 0, "R9 reset state");
        step(1, 0, 0, "R1 quiet sample");
        lt = deg(50);                         step(1, 0, 0, "R1 R2 local exactly at high limit");
        ie_loc_oor = 1;                       step(0, 0, 0, "R2 enabled local out-of-range alert");
        lt = deg(50) - 1;                     step(0, 0, 0, "R1 flags held without sample");
        step(1, 0, 0, "R1 R10 one LSB under high limit releases alert");
        lt = deg(-10);                        step(1, 0, 0, "R1 local at low limit");
        lt = deg(0); rt = deg(0);             step(1, 0, 0, "R1 remote at low limit 0");
        rt = -8; ie_rem_oor = 1;              step(1, 0, 0, "R2 remote -1 degree low alert");
        rt = deg(40); ie_loc_oor = 0; ie_rem_oor = 0;
        lt = deg(25);                         step(1, 0, 0, "R10 alert released");
        rt = deg(90);                         step(1, 0, 0, "R3 remote critical non-maskable");
        rt = deg(90) - 1;                     step(1, 0, 0, "R3 critical cleared below limit");
        lt = deg(30); rt = deg(40); ctl_sel = 2'd2;
        step(1, 0, 0, "R5 greater of two above passive limit");
        ctl_sel = 2'd0;                       step(1, 0, 0, "R5 local at passive limit");
        ie_psv = 1;                           step(0, 0, 0, "R4 passive alert enabled");
        step(1, 0, 1, "R4 read clear wins over set");
        step(0, 0, 0, "R4 still clear without sample");
        step(1, 0, 0, "R4 reasserts on next sample");
        lt = deg(31);                         step(0, 0, 1, "R4 read clears");
        step(1, 0, 0, "R4 no reassert when warm");
        ctl_sel = 2'd1; rt = deg(30);         step(1, 0, 0, "R5 remote selected");
        ctl_sel = 2'd3; step(1, 0, 1, "R5 code 3 greater, cleared same cycle");
        step(1, 0, 0, "R5 code 3 uses greater reading");
        ie_psv = 0; rt = deg(40);             step(0, 0, 1, "R4 clear before THERM tests");
        fan_force_en = 1; lt = deg(80);       step(1, 0, 0, "R6 R8 local THERM set");
        ie_therm = 1;                         step(0, 0, 0, "R6 THERM alert enabled");
        step(1, 1, 0, "R7 read clears THERM");
        step(1, 0, 0, "R7 stays clear while hot");
        lt = deg(76);                         step(1, 0, 0, "R7 above re-arm level");
        lt = deg(75);                         step(1, 0, 0, "R7 re-arm at limit minus 5");
        lt = deg(80);                         step(1, 0, 0, "R7 sets again after re-arm");
        fan_force_en = 0;                     step(0, 0, 0, "R8 fan force off");
        fan_force_en = 1;                     step(0, 0, 0, "R8 fan force on");
        th_lim = -125; lt = deg(0);           step(1, 0, 0, "R6 both channels hot vs low limit");
        step(1, 1, 0, "R7 clear with low THERM limit");
        lt = deg(-127); rt = deg(-127);       step(1, 0, 0, "R7 no re-arm above saturated level");
        lt = deg(-128);                       step(1, 0, 0, "R7 local re-arms at -128");
        lt = deg(0);                          step(1, 0, 0, "R7 local sets after saturated re-arm");
        ie_therm = 0; fan_force_en = 0;       step(1, 1, 0, "R10 all sources clear");
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule